// File: doc/BRIEF.md
# Integer ALU and Shifter

This unit is the arithmetic stage of a 32-bit load/store processor. Each cycle it can accept one operation, given as the raw 6-bit major opcode and 6-bit function field together with two register operands, a 16-bit immediate and a 5-bit shift count. A small decoder turns the opcode and function field into an internal operation select. The datapath then produces a 32-bit result and an overflow flag. Both are registered, so they appear one clock after the operation is presented.

Several operation families are covered. Addition and subtraction come in trapping forms, which raise the overflow flag on signed overflow, and in wrapping forms, which never raise it. The other families are bitwise logic, signed and unsigned compare-and-set, and shifts by a constant or by a register amount in logical and arithmetic forms. Immediate forms replace the second operand with the immediate. That immediate is sign-extended or zero-extended according to the opcode. The register file, the pipeline control, branches and memory access all live outside this block.

Top module: `alu_exec`

## Requirements
- R1: `out_valid` rises exactly one cycle after `in_valid` is sampled high, and is low in the cycle after a low sample. `result` and `overflow` change only in cycles that follow an accepted operation, and otherwise hold their values. After reset all three outputs are 0.
- R2: With opcode 000000, function codes 100000 (add), 100001 (addu), 100010 (sub) and 100011 (subu) give `src_a + src_b` or `src_a - src_b` modulo 2^32.
- R3: add, sub and addi raise `overflow` when the true signed result does not fit in 32 bits. addu, subu and addiu never raise it, and no other operation raises it.
- R4: With opcode 000000, function codes 100100, 100101, 100110 and 100111 give AND, OR, XOR and NOR (the inverted OR) of `src_a` and `src_b`.
- R5: Function 101010 (slt) writes 1 if `src_a < src_b` taken as two's-complement numbers, and 0 otherwise. Function 101011 (sltu) makes the same comparison taken as unsigned numbers.
- R6: The immediate opcodes use `src_a` as the first operand and the extended immediate as the second. Opcodes 001000 (addi), 001001 (addiu), 001010 (slti) and 001011 (sltiu) copy immediate bit 15 into bits 31:16. Opcodes 001100 (andi), 001101 (ori) and 001110 (xori) fill bits 31:16 with zeros.
- R7: Opcode 001111 places the immediate in bits 31:16 of the result, with zeros in bits 15:0.
- R8: Function codes 000000 (sll), 000010 (srl) and 000011 (sra) shift `src_b` by `shamt`.
- R9: Function codes 000100 (sllv), 000110 (srlv) and 000111 (srav) shift `src_b` by `src_a[4:0]`. Bits 31:5 of `src_a` have no effect.
- R10: Arithmetic right shifts fill vacated bits with bit 31 of `src_b`. Logical left and right shifts fill them with zeros.
- R11: Any other opcode, or any other function code under opcode 000000, gives a result of 0 and no overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | An operation is presented this cycle |
| opcode | input | 6 | Major opcode; 000000 selects the function field |
| funct | input | 6 | Function field for opcode 000000 |
| src_a | input | 32 | First register operand; also the variable shift count |
| src_b | input | 32 | Second register operand; also the shifted value |
| imm | input | 16 | Immediate field |
| shamt | input | 5 | Constant shift count |
| out_valid | output | 1 | Result registered from the previous cycle's operation |
| result | output | 32 | Operation result |
| overflow | output | 1 | Signed overflow from a trapping add or subtract |

## Verification
The hardest case to reach is signed overflow on subtraction. The operands have opposite signs there, so the flag depends on the inverted second operand and not on the raw one. The stimulus aims directly at both boundaries: the most negative value minus a positive value, and zero minus the most negative value. It repeats these with the wrapping forms to show that the flag stays low. Variable shifts are fed counts whose upper register bits are set, so any leak of those bits into the shift would change the result. Sign-extended immediates with bit 15 set are compared against zero-extended ones. A stream of random operations with idle gaps then exercises the result-hold behaviour.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int unsigned CODE_W = 6;

    // major opcodes
    localparam logic [CODE_W-1:0] OPC_RTYPE = 6'b000000;
    localparam logic [CODE_W-1:0] OPC_ADDI  = 6'b001000;
    localparam logic [CODE_W-1:0] OPC_ADDIU = 6'b001001;
    localparam logic [CODE_W-1:0] OPC_SLTI  = 6'b001010;
    localparam logic [CODE_W-1:0] OPC_SLTIU = 6'b001011;
    localparam logic [CODE_W-1:0] OPC_ANDI  = 6'b001100;
    localparam logic [CODE_W-1:0] OPC_ORI   = 6'b001101;
    localparam logic [CODE_W-1:0] OPC_XORI  = 6'b001110;
    localparam logic [CODE_W-1:0] OPC_LUI   = 6'b001111;

    // function field values under OPC_RTYPE
    localparam logic [CODE_W-1:0] FN_SLL  = 6'b000000;
    localparam logic [CODE_W-1:0] FN_SRL  = 6'b000010;
    localparam logic [CODE_W-1:0] FN_SRA  = 6'b000011;
    localparam logic [CODE_W-1:0] FN_SLLV = 6'b000100;
    localparam logic [CODE_W-1:0] FN_SRLV = 6'b000110;
    localparam logic [CODE_W-1:0] FN_SRAV = 6'b000111;
    localparam logic [CODE_W-1:0] FN_ADD  = 6'b100000;
    localparam logic [CODE_W-1:0] FN_ADDU = 6'b100001;
    localparam logic [CODE_W-1:0] FN_SUB  = 6'b100010;
    localparam logic [CODE_W-1:0] FN_SUBU = 6'b100011;
    localparam logic [CODE_W-1:0] FN_AND  = 6'b100100;
    localparam logic [CODE_W-1:0] FN_OR   = 6'b100101;
    localparam logic [CODE_W-1:0] FN_XOR  = 6'b100110;
    localparam logic [CODE_W-1:0] FN_NOR  = 6'b100111;
    localparam logic [CODE_W-1:0] FN_SLT  = 6'b101010;
    localparam logic [CODE_W-1:0] FN_SLTU = 6'b101011;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_ADD,
        OP_SUB,
        OP_AND,
        OP_OR,
        OP_XOR,
        OP_NOR,
        OP_SLT,
        OP_SLTU,
        OP_SLL,
        OP_SRL,
        OP_SRA,
        OP_LUI
    } alu_op_e;

    typedef enum logic [1:0] {
        IMM_OFF,
        IMM_SEXT,
        IMM_ZEXT
    } imm_mode_e;

    typedef struct packed {
        alu_op_e   op;
        imm_mode_e imm_mode;
        logic      var_shift;
        logic      traps;
        logic      legal;
    } alu_ctl_t;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
    import alu_pkg::*;
(
    input  logic [CODE_W-1:0] opcode,
    input  logic [CODE_W-1:0] funct,
    output alu_ctl_t          ctl
);

    alu_ctl_t ctl_d;

    always_comb begin
        ctl_d           = '0;
        ctl_d.op        = OP_NONE;
        ctl_d.imm_mode  = IMM_OFF;
        ctl_d.legal     = 1'b1;
        unique case (opcode)
            OPC_RTYPE: begin
                unique case (funct)
                    FN_ADD:  begin ctl_d.op = OP_ADD; ctl_d.traps = 1'b1; end
                    FN_ADDU: ctl_d.op = OP_ADD;
                    FN_SUB:  begin ctl_d.op = OP_SUB; ctl_d.traps = 1'b1; end
                    FN_SUBU: ctl_d.op = OP_SUB;
                    FN_AND:  ctl_d.op = OP_AND;
                    FN_OR:   ctl_d.op = OP_OR;
                    FN_XOR:  ctl_d.op = OP_XOR;
                    FN_NOR:  ctl_d.op = OP_NOR;
                    FN_SLT:  ctl_d.op = OP_SLT;
                    FN_SLTU: ctl_d.op = OP_SLTU;
                    FN_SLL:  ctl_d.op = OP_SLL;
                    FN_SRL:  ctl_d.op = OP_SRL;
                    FN_SRA:  ctl_d.op = OP_SRA;
                    FN_SLLV: begin ctl_d.op = OP_SLL; ctl_d.var_shift = 1'b1; end
                    FN_SRLV: begin ctl_d.op = OP_SRL; ctl_d.var_shift = 1'b1; end
                    FN_SRAV: begin ctl_d.op = OP_SRA; ctl_d.var_shift = 1'b1; end
                    default: ctl_d.legal = 1'b0;
                endcase
            end
            OPC_ADDI: begin
                ctl_d.op       = OP_ADD;
                ctl_d.imm_mode = IMM_SEXT;
                ctl_d.traps    = 1'b1;
            end
            OPC_ADDIU: begin
                ctl_d.op       = OP_ADD;
                ctl_d.imm_mode = IMM_SEXT;
            end
            OPC_SLTI: begin
                ctl_d.op       = OP_SLT;
                ctl_d.imm_mode = IMM_SEXT;
            end
            OPC_SLTIU: begin
                ctl_d.op       = OP_SLTU;
                ctl_d.imm_mode = IMM_SEXT;
            end
            OPC_ANDI: begin
                ctl_d.op       = OP_AND;
                ctl_d.imm_mode = IMM_ZEXT;
            end
            OPC_ORI: begin
                ctl_d.op       = OP_OR;
                ctl_d.imm_mode = IMM_ZEXT;
            end
            OPC_XORI: begin
                ctl_d.op       = OP_XOR;
                ctl_d.imm_mode = IMM_ZEXT;
            end
            OPC_LUI: ctl_d.op = OP_LUI;
            default: ctl_d.legal = 1'b0;
        endcase
        if (!ctl_d.legal) begin
            ctl_d.op        = OP_NONE;
            ctl_d.traps     = 1'b0;
            ctl_d.var_shift = 1'b0;
            ctl_d.imm_mode  = IMM_OFF;
        end
    end

    assign ctl = ctl_d;

endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
    parameter int unsigned WIDTH = 32,
    localparam int unsigned AMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] data_in,
    input  logic [AMT_W-1:0] amount,
    input  logic             to_left,
    input  logic             arith,
    output logic [WIDTH-1:0] data_out
);

    // Left shifts run through the right-shift ladder on bit-reversed data.
    logic [WIDTH-1:0] rev_in;
    logic [WIDTH-1:0] ladder [AMT_W+1];
    logic [WIDTH-1:0] rev_out;
    logic             fill_bit;

    assign fill_bit = arith & ~to_left & data_in[WIDTH-1];

    for (genvar i = 0; i < WIDTH; i++) begin : g_rev_in
        assign rev_in[i] = data_in[WIDTH-1-i];
    end

    assign ladder[0] = to_left ? rev_in : data_in;

    for (genvar k = 0; k < AMT_W; k++) begin : g_stage
        localparam int unsigned STEP = 1 << k;
        assign ladder[k+1] = amount[k]
                           ? {{STEP{fill_bit}}, ladder[k][WIDTH-1:STEP]}
                           : ladder[k];
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_rev_out
        assign rev_out[i] = ladder[AMT_W][WIDTH-1-i];
    end

    assign data_out = to_left ? rev_out : ladder[AMT_W];

endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IMM_W  = 16,
    localparam int unsigned AMT_W = $clog2(DATA_W)
) (
    input  alu_ctl_t          ctl,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [IMM_W-1:0]  imm,
    input  logic [AMT_W-1:0]  shamt,
    output logic [DATA_W-1:0] res,
    output logic              ovf
);

    localparam int unsigned EXT_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_ext;
    logic [DATA_W-1:0] opnd_b;
    logic              is_sub;
    logic [DATA_W-1:0] b_eff;
    logic [DATA_W-1:0] sum;
    logic              sum_ovf;
    logic              lt_signed;
    logic              lt_unsigned;
    logic [AMT_W-1:0]  sh_amt;
    logic              sh_left;
    logic              sh_arith;
    logic [DATA_W-1:0] sh_res;

    // immediate extension chosen by the decoded mode
    always_comb begin
        unique case (ctl.imm_mode)
            IMM_SEXT: imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
            IMM_ZEXT: imm_ext = {{EXT_W{1'b0}}, imm};
            default:  imm_ext = '0;
        endcase
    end

    assign opnd_b = (ctl.imm_mode == IMM_OFF) ? src_b : imm_ext;

    // shared adder; subtraction adds the inverted operand plus one
    assign is_sub  = (ctl.op == OP_SUB);
    assign b_eff   = is_sub ? ~opnd_b : opnd_b;
    assign sum     = src_a + b_eff + DATA_W'(is_sub);
    assign sum_ovf = (src_a[DATA_W-1] == b_eff[DATA_W-1])
                   && (sum[DATA_W-1] != src_a[DATA_W-1]);

    assign lt_signed   = $signed(src_a) < $signed(opnd_b);
    assign lt_unsigned = src_a < opnd_b;

    // shifter: register count uses only the low bits of src_a
    assign sh_amt   = ctl.var_shift ? src_a[AMT_W-1:0] : shamt;
    assign sh_left  = (ctl.op == OP_SLL);
    assign sh_arith = (ctl.op == OP_SRA);

    alu_shift #(
        .WIDTH (DATA_W)
    ) u_shift (
        .data_in  (src_b),
        .amount   (sh_amt),
        .to_left  (sh_left),
        .arith    (sh_arith),
        .data_out (sh_res)
    );

    always_comb begin
        res = '0;
        ovf = 1'b0;
        unique case (ctl.op)
            OP_ADD, OP_SUB: begin
                res = sum;
                ovf = ctl.traps & sum_ovf;
            end
            OP_AND:  res = src_a & opnd_b;
            OP_OR:   res = src_a | opnd_b;
            OP_XOR:  res = src_a ^ opnd_b;
            OP_NOR:  res = ~(src_a | opnd_b);
            OP_SLT:  res = {{(DATA_W-1){1'b0}}, lt_signed};
            OP_SLTU: res = {{(DATA_W-1){1'b0}}, lt_unsigned};
            OP_SLL, OP_SRL, OP_SRA: res = sh_res;
            OP_LUI:  res = {imm, {EXT_W{1'b0}}};
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/alu_exec.sv
module alu_exec
    import alu_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IMM_W  = 16,
    localparam int unsigned AMT_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [5:0]        opcode,
    input  logic [5:0]        funct,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [IMM_W-1:0]  imm,
    input  logic [AMT_W-1:0]  shamt,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              overflow
);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] res;
        logic              ovf;
    } out_st_t;

    alu_ctl_t          ctl;
    logic [DATA_W-1:0] core_res;
    logic              core_ovf;
    out_st_t           out_d;
    out_st_t           out_q;

    alu_decode u_decode (
        .opcode (opcode),
        .funct  (funct),
        .ctl    (ctl)
    );

    alu_core #(
        .DATA_W (DATA_W),
        .IMM_W  (IMM_W)
    ) u_core (
        .ctl   (ctl),
        .src_a (src_a),
        .src_b (src_b),
        .imm   (imm),
        .shamt (shamt),
        .res   (core_res),
        .ovf   (core_ovf)
    );

    always_comb begin
        out_d       = out_q;
        out_d.valid = in_valid;
        if (in_valid) begin
            out_d.res = core_res;
            out_d.ovf = core_ovf;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_valid = out_q.valid;
    assign result    = out_q.res;
    assign overflow  = out_q.ovf;

    // R1: one-cycle handshake and hold
    p_valid_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(overflow)));

    // R3: wrapping add/subtract never flags
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ((opcode == OPC_RTYPE && (funct == FN_ADDU || funct == FN_SUBU))
                      || opcode == OPC_ADDIU)) |=> !overflow);

    // R5: compare-and-set writes a single bit
    p_set_bool_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (ctl.op == OP_SLT || ctl.op == OP_SLTU))
        |=> (result[DATA_W-1:1] == '0));

    // R7: low half of upper-immediate load is zero
    p_lui_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == OPC_LUI) |=> (result[DATA_W-IMM_W-1:0] == '0));

    // R10: logical right shift by a nonzero count clears the top bit
    p_srl_top_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == OPC_RTYPE && funct == FN_SRL && shamt != '0)
        |=> !result[DATA_W-1]);

    // R11: unrecognised codes give zero
    p_illegal_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !ctl.legal) |=> (result == '0 && !overflow));

endmodule

// File: tb/tb_alu_exec.sv
module tb_alu_exec;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [5:0]  opcode = '0;
    logic [5:0]  funct = '0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [15:0] imm = '0;
    logic [4:0]  shamt = '0;
    logic        out_valid;
    logic [31:0] result;
    logic        overflow;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [31:0] res;
        logic        ovf;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    alu_exec dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .opcode    (opcode),
        .funct     (funct),
        .src_a     (src_a),
        .src_b     (src_b),
        .imm       (imm),
        .shamt     (shamt),
        .out_valid (out_valid),
        .result    (result),
        .overflow  (overflow)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic bit ovf32(input longint v);
        return (v > 64'sd2147483647) || (v < -64'sd2147483648);
    endfunction

    // reference model written from the requirements
    function automatic exp_t model(input logic [5:0] opc, input logic [5:0] fn,
                                   input logic [31:0] a, input logic [31:0] b,
                                   input logic [15:0] im, input logic [4:0] sh);
        exp_t e;
        logic [31:0] se, ze;
        longint sa, sb;
        se = {{16{im[15]}}, im};
        ze = {16'h0, im};
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        e.res = 32'h0; e.ovf = 1'b0; e.tag = "R11";
        if (opc == 6'b000000) begin
            case (fn)
                6'b100000: begin e.res = a + b; e.ovf = ovf32(sa + sb); e.tag = "R3"; end
                6'b100001: begin e.res = a + b; e.tag = "R2"; end
                6'b100010: begin e.res = a - b; e.ovf = ovf32(sa - sb); e.tag = "R3"; end
                6'b100011: begin e.res = a - b; e.tag = "R2"; end
                6'b100100: begin e.res = a & b; e.tag = "R4"; end
                6'b100101: begin e.res = a | b; e.tag = "R4"; end
                6'b100110: begin e.res = a ^ b; e.tag = "R4"; end
                6'b100111: begin e.res = ~(a | b); e.tag = "R4"; end
                6'b101010: begin e.res = {31'h0, sa < sb}; e.tag = "R5"; end
                6'b101011: begin e.res = {31'h0, a < b}; e.tag = "R5"; end
                6'b000000: begin e.res = b << sh; e.tag = "R8"; end
                6'b000010: begin e.res = b >> sh; e.tag = "R8"; end
                6'b000011: begin e.res = 32'($signed(b) >>> sh); e.tag = "R10"; end
                6'b000100: begin e.res = b << a[4:0]; e.tag = "R9"; end
                6'b000110: begin e.res = b >> a[4:0]; e.tag = "R9"; end
                6'b000111: begin e.res = 32'($signed(b) >>> a[4:0]); e.tag = "R9"; end
                default: ;
            endcase
        end else begin
            case (opc)
                6'b001000: begin e.res = a + se; e.ovf = ovf32(sa + longint'($signed(se))); e.tag = "R6"; end
                6'b001001: begin e.res = a + se; e.tag = "R6"; end
                6'b001010: begin e.res = {31'h0, sa < longint'($signed(se))}; e.tag = "R6"; end
                6'b001011: begin e.res = {31'h0, a < se}; e.tag = "R6"; end
                6'b001100: begin e.res = a & ze; e.tag = "R6"; end
                6'b001101: begin e.res = a | ze; e.tag = "R6"; end
                6'b001110: begin e.res = a ^ ze; e.tag = "R6"; end
                6'b001111: begin e.res = {im, 16'h0}; e.tag = "R7"; end
                default: ;
            endcase
        end
        return e;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [32:0] act,
                         input logic [32:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [5:0] opc, input logic [5:0] fn,
                         input logic [31:0] a, input logic [31:0] b,
                         input logic [15:0] im, input logic [4:0] sh);
        @(negedge clk);
        in_valid = 1'b1;
        opcode = opc; funct = fn; src_a = a; src_b = b; imm = im; shamt = sh;
        exp_q.push_back(model(opc, fn, a, b, im, sh));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            opcode = 6'($urandom); funct = 6'($urandom);
            src_a = $urandom; src_b = $urandom; imm = 16'($urandom);
            shamt = 5'($urandom);
        end
    endtask

    // monitor: pops expected items as results appear
    logic [31:0] last_res = '0;
    logic        last_ovf = 1'b0;
    bit          mon_on = 0;
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_P/4);
            if (mon_on) begin
                if (out_valid) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R1 unexpected out_valid", 33'h1, 33'h0);
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        check(result === e.res && overflow === e.ovf, e.tag,
                              {overflow, result}, {e.ovf, e.res});
                    end
                    last_res = result;
                    last_ovf = overflow;
                end else begin
                    // R1: hold while idle
                    check(result === last_res && overflow === last_ovf, "R1 hold",
                          {overflow, result}, {last_ovf, last_res});
                end
            end
        end
    end

    task automatic pick(input int idx, output logic [5:0] opc, output logic [5:0] fn);
        logic [5:0] rfn [16] = '{6'b100000, 6'b100001, 6'b100010, 6'b100011,
                                 6'b100100, 6'b100101, 6'b100110, 6'b100111,
                                 6'b101010, 6'b101011, 6'b000000, 6'b000010,
                                 6'b000011, 6'b000100, 6'b000110, 6'b000111};
        if (idx < 16) begin
            opc = 6'b000000; fn = rfn[idx];
        end else begin
            opc = 6'(6'b001000 + idx - 16); fn = 6'($urandom);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // reset state, R1
        check(out_valid === 1'b0 && result === 32'h0 && overflow === 1'b0,
              "R1 reset", {overflow, result}, 33'h0);
        rst_n = 1'b1;
        mon_on = 1;

        // R2 wrap, R3 overflow boundaries
        drive(6'b000000, 6'b100000, 32'h7fffffff, 32'h1, 16'h0, 5'd0);
        drive(6'b000000, 6'b100001, 32'h7fffffff, 32'h1, 16'h0, 5'd0);
        drive(6'b000000, 6'b100010, 32'h80000000, 32'h1, 16'h0, 5'd0);
        drive(6'b000000, 6'b100010, 32'h0, 32'h80000000, 16'h0, 5'd0);
        drive(6'b000000, 6'b100011, 32'h0, 32'h80000000, 16'h0, 5'd0);
        drive(6'b000000, 6'b100000, 32'h80000000, 32'h80000000, 16'h0, 5'd0);
        drive(6'b000000, 6'b100010, 32'hffffffff, 32'h7fffffff, 16'h0, 5'd0);
        drive(6'b001000, 6'b000000, 32'h7fffffff, 32'h0, 16'h0001, 5'd0);
        drive(6'b001000, 6'b000000, 32'h80000000, 32'h0, 16'hffff, 5'd0);
        drive(6'b001001, 6'b000000, 32'h7fffffff, 32'h0, 16'h0001, 5'd0);
        // R4 logic
        drive(6'b000000, 6'b100111, 32'hf0f00000, 32'h00ff00ff, 16'h0, 5'd0);
        drive(6'b000000, 6'b100110, 32'hdeadbeef, 32'hffff0000, 16'h0, 5'd0);
        // R5 compares
        drive(6'b000000, 6'b101010, 32'hffffffff, 32'h1, 16'h0, 5'd0);
        drive(6'b000000, 6'b101011, 32'hffffffff, 32'h1, 16'h0, 5'd0);
        // R6 extension
        drive(6'b001100, 6'b000000, 32'hffffffff, 32'h0, 16'h8001, 5'd0);
        drive(6'b001101, 6'b000000, 32'h0, 32'h0, 16'hffff, 5'd0);
        drive(6'b001110, 6'b000000, 32'h12345678, 32'h0, 16'h8000, 5'd0);
        drive(6'b001010, 6'b000000, 32'hfffffff0, 32'h0, 16'hffff, 5'd0);
        drive(6'b001011, 6'b000000, 32'hfffffff0, 32'h0, 16'hffff, 5'd0);
        // R7
        drive(6'b001111, 6'b000000, 32'hffffffff, 32'hffffffff, 16'hbeef, 5'd0);
        // R8, R10 constant shifts
        drive(6'b000000, 6'b000011, 32'h0, 32'h80000000, 16'h0, 5'd31);
        drive(6'b000000, 6'b000010, 32'h0, 32'h80000000, 16'h0, 5'd31);
        drive(6'b000000, 6'b000000, 32'h0, 32'h80000001, 16'h0, 5'd1);
        // R9 variable shifts with upper count bits set
        drive(6'b000000, 6'b000100, 32'hffffffe4, 32'h0000000f, 16'h0, 5'd0);
        drive(6'b000000, 6'b000111, 32'h12345608, 32'h80001234, 16'h0, 5'd0);
        drive(6'b000000, 6'b000110, 32'hffffffe0, 32'h80001234, 16'h0, 5'd3);
        // R11 illegal codes
        drive(6'b111111, 6'b100000, 32'h7fffffff, 32'h1, 16'hffff, 5'd3);
        drive(6'b000000, 6'b001001, 32'h7fffffff, 32'h1, 16'hffff, 5'd3);
        idle(3);

        // random stream with gaps
        for (int n = 0; n < 400; n++) begin
            logic [5:0] opc, fn;
            pick($urandom_range(0, 23), opc, fn);
            drive(opc, fn, $urandom, $urandom, 16'($urandom), 5'($urandom));
            if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 2));
        end
        idle(3);
        check(exp_q.size() == 0, "R1 drained", 33'(exp_q.size()), 33'h0);
        done = 1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (100000) @(posedge clk);
                errors++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule